// File: doc/BRIEF.md
# Video Storage Write-Enable Controller

This block decides, sample by sample, whether digitised video may be written into a field store. It keeps a half-line position within the field in a counter that a vertical-rate sync pulse sets back to zero. From that position, the selected video standard and two mode inputs, it produces a write-enable level and a one-clock read/write strobe for each sample tick on which writing is allowed.

There are three modes, checked in a fixed priority order:

- **Freeze** blocks every write, so the store keeps replaying the field it already holds.
- **Selected line** writes only during a line in which a line-select pulse arrived. Without such a pulse the stored line is left alone and is shown again on each pass.
- **Full field** writes every active half-line and holds writes off across the vertical interval at the start of each field.

The sample datapath and the store itself are outside this block.

Top module: `vid_wr_ctrl`

## Requirements
- R1: While `rst_n` is low, `we` and `rw` are 0. After reset the half-line position is 0, so full-field mode starts inside the vertical interval with `we` low.
- R2: A high `vsync` on a clock edge sets the half-line position to 0. This takes priority over `hl_tick`.
- R3: With `std_sel` = 1 (525/60), full-field mode holds `we` low for half-line positions 0 to 41 and drives it high from position 42 on.
- R4: With `std_sel` = 0 (625/50), full-field mode holds `we` low for half-line positions 0 to 49 and drives it high from position 50 on.
- R5: Each `hl_tick` adds one to the position, up to the field length: 525 half-lines for `std_sel` = 1 and 625 for `std_sel` = 0. Once it reaches that length the position stays there until `vsync` arrives and does not wrap.
- R6: `rw` is high for exactly one clock, in the cycle after an `smp_tick` that was sampled while the next `we` value is 1. `rw` is never high while `we` is low.
- R7: In full-field mode, no `rw` strobe is produced inside the vertical interval.
- R8: `lsel_mode_n` = 0 selects selected-line mode. An `lsel_pulse` arms writing, and `we` is high while the line is armed. The line is disarmed by an `hl_tick` taken at an odd half-line position, which is the end of a line. In this mode the vertical-interval rule does not apply.
- R9: In selected-line mode with no `lsel_pulse`, `we` stays 0 and `smp_tick` produces no `rw` strobe, even during active half-lines.
- R10: `frz_n` = 0 forces `we` and `rw` to 0 in both other modes. When `frz_n` returns high, the mode selected by `lsel_mode_n` takes effect again.
- R11: `vsync` disarms a selected line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hl_tick | input | 1 | One-clock pulse at each half-line |
| vsync | input | 1 | Vertical-rate sync; zeroes the half-line position |
| std_sel | input | 1 | 1 = 525/60 timing, 0 = 625/50 timing |
| lsel_mode_n | input | 1 | 0 = selected-line mode, 1 = full-field mode |
| frz_n | input | 1 | 0 = freeze, blocks all writes |
| lsel_pulse | input | 1 | Line-select pulse that arms the current line |
| smp_tick | input | 1 | One-clock pulse for each video sample |
| we | output | 1 | Storage write enable |
| rw | output | 1 | Gated read/write strobe, one clock per permitted sample |

## Verification
A half-line position that is wrong appears at `we` as a vertical-interval edge at the wrong place. `we` moves one clock after the position register, so the error shows two clocks after the `hl_tick` that crosses the boundary. A counter that wraps instead of holding shows up only after some 4096 ticks without sync, when `we` drops back low. An armed flag stuck high or low appears in selected-line mode as `we` ignoring the line end or the select pulse, again within two clocks. Wrong mode priority appears as `we` or `rw` high while `frz_n` is low.

// File: rtl/vwc_pkg.sv
package vwc_pkg;
    localparam int VWC_CNT_W  = 12;
    localparam int VWC_HL_525 = 525;
    localparam int VWC_HL_625 = 625;
    localparam int VWC_VB_525 = 42;
    localparam int VWC_VB_625 = 50;

    typedef enum logic [1:0] {
        MODE_FULL   = 2'd0,
        MODE_LINE   = 2'd1,
        MODE_FREEZE = 2'd2
    } wr_mode_e;
endpackage

// File: rtl/vwc_hlcnt.sv
module vwc_hlcnt #(
    parameter int CNT_W  = vwc_pkg::VWC_CNT_W,
    parameter int HL_525 = vwc_pkg::VWC_HL_525,
    parameter int HL_625 = vwc_pkg::VWC_HL_625,
    parameter int VB_525 = vwc_pkg::VWC_VB_525,
    parameter int VB_625 = vwc_pkg::VWC_VB_625
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hl_tick,
    input  logic             vsync,
    input  logic             std_sel,
    output logic [CNT_W-1:0] cnt,
    output logic             in_vbi,
    output logic             line_end
);
    localparam logic [CNT_W-1:0] FLEN_A = CNT_W'(HL_525);
    localparam logic [CNT_W-1:0] FLEN_B = CNT_W'(HL_625);
    localparam logic [CNT_W-1:0] VLEN_A = CNT_W'(VB_525);
    localparam logic [CNT_W-1:0] VLEN_B = CNT_W'(VB_625);

    typedef struct packed {
        logic [CNT_W-1:0] pos;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic [CNT_W-1:0] flen;
    logic [CNT_W-1:0] vlen;

    always_comb begin
        st_d = st_q;
        flen = std_sel ? FLEN_A : FLEN_B;
        vlen = std_sel ? VLEN_A : VLEN_B;
        if (vsync) begin
            st_d.pos = '0;
        end else if (hl_tick && (st_q.pos < flen)) begin
            st_d.pos = st_q.pos + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt      = st_q.pos;
    assign in_vbi   = (st_q.pos < vlen);
    assign line_end = hl_tick & st_q.pos[0] & ~vsync;
endmodule

// File: rtl/vwc_linearm.sv
module vwc_linearm (
    input  logic clk,
    input  logic rst_n,
    input  logic vsync,
    input  logic lsel_pulse,
    input  logic line_end,
    output logic armed
);
    typedef struct packed {
        logic armed;
    } arm_st_t;

    arm_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (vsync) begin
            st_d.armed = 1'b0;
        end else if (lsel_pulse) begin
            st_d.armed = 1'b1;
        end else if (line_end) begin
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign armed = st_q.armed;
endmodule

// File: rtl/vwc_wrgate.sv
module vwc_wrgate
    import vwc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frz_n,
    input  logic lsel_mode_n,
    input  logic in_vbi,
    input  logic armed,
    input  logic smp_tick,
    output logic we,
    output logic rw
);
    typedef struct packed {
        logic we;
        logic rw;
    } gate_st_t;

    gate_st_t st_d, st_q;
    wr_mode_e mode;

    always_comb begin
        if (!frz_n) begin
            mode = MODE_FREEZE;
        end else if (!lsel_mode_n) begin
            mode = MODE_LINE;
        end else begin
            mode = MODE_FULL;
        end

        st_d = st_q;
        unique case (mode)
            MODE_FREEZE: st_d.we = 1'b0;
            MODE_LINE:   st_d.we = armed;
            MODE_FULL:   st_d.we = ~in_vbi;
            default:     st_d.we = 1'b0;
        endcase
        st_d.rw = smp_tick & st_d.we;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign we = st_q.we;
    assign rw = st_q.rw;
endmodule

// File: rtl/vid_wr_ctrl.sv
module vid_wr_ctrl #(
    parameter int CNT_W  = vwc_pkg::VWC_CNT_W,
    parameter int HL_525 = vwc_pkg::VWC_HL_525,
    parameter int HL_625 = vwc_pkg::VWC_HL_625,
    parameter int VB_525 = vwc_pkg::VWC_VB_525,
    parameter int VB_625 = vwc_pkg::VWC_VB_625
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hl_tick,
    input  logic vsync,
    input  logic std_sel,
    input  logic lsel_mode_n,
    input  logic frz_n,
    input  logic lsel_pulse,
    input  logic smp_tick,
    output logic we,
    output logic rw
);
    logic [CNT_W-1:0] cnt_w;
    logic             in_vbi_w;
    logic             line_end_w;
    logic             armed_w;

    vwc_hlcnt #(
        .CNT_W (CNT_W),
        .HL_525(HL_525),
        .HL_625(HL_625),
        .VB_525(VB_525),
        .VB_625(VB_625)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .hl_tick (hl_tick),
        .vsync   (vsync),
        .std_sel (std_sel),
        .cnt     (cnt_w),
        .in_vbi  (in_vbi_w),
        .line_end(line_end_w)
    );

    vwc_linearm u_arm (
        .clk       (clk),
        .rst_n     (rst_n),
        .vsync     (vsync),
        .lsel_pulse(lsel_pulse),
        .line_end  (line_end_w),
        .armed     (armed_w)
    );

    vwc_wrgate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .frz_n      (frz_n),
        .lsel_mode_n(lsel_mode_n),
        .in_vbi     (in_vbi_w),
        .armed      (armed_w),
        .smp_tick   (smp_tick),
        .we         (we),
        .rw         (rw)
    );
endmodule

// File: rtl/vwc_chk.sv
module vwc_chk #(
    parameter int CNT_W  = 12,
    parameter int HL_525 = 525,
    parameter int HL_625 = 625,
    parameter int VB_525 = 42,
    parameter int VB_625 = 50
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hl_tick,
    input logic             vsync,
    input logic             std_sel,
    input logic             lsel_mode_n,
    input logic             frz_n,
    input logic             smp_tick,
    input logic             we,
    input logic             rw,
    input logic [CNT_W-1:0] cnt,
    input logic             armed
);
    logic [CNT_W-1:0] flen_c;
    logic [CNT_W-1:0] vlen_c;
    assign flen_c = std_sel ? CNT_W'(HL_525) : CNT_W'(HL_625);
    assign vlen_c = std_sel ? CNT_W'(VB_525) : CNT_W'(VB_625);

    AST_VSYNC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        vsync |=> (cnt == '0)); // R2

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (hl_tick && !vsync && (cnt >= flen_c)) |=> (cnt == $past(cnt))); // R5

    AST_RW_NEEDS_WE: assert property (@(posedge clk) disable iff (!rst_n)
        rw |-> we); // R6

    AST_RW_FROM_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        rw |-> $past(smp_tick)); // R6

    AST_VBI_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (frz_n && lsel_mode_n && (cnt < vlen_c)) |=> (!we && !rw)); // R7

    AST_LINE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        (!lsel_mode_n && !armed) |=> !we); // R8

    AST_FREEZE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !frz_n |=> (!we && !rw)); // R10

    AST_VSYNC_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
        vsync |=> !armed); // R11
endmodule

bind vid_wr_ctrl vwc_chk #(
    .CNT_W (CNT_W),
    .HL_525(HL_525),
    .HL_625(HL_625),
    .VB_525(VB_525),
    .VB_625(VB_625)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hl_tick    (hl_tick),
    .vsync      (vsync),
    .std_sel    (std_sel),
    .lsel_mode_n(lsel_mode_n),
    .frz_n      (frz_n),
    .smp_tick   (smp_tick),
    .we         (we),
    .rw         (rw),
    .cnt        (cnt_w),
    .armed      (armed_w)
);

// File: tb/sim_vid_wr_ctrl.sv
`timescale 1ns/1ps
module sim_vid_wr_ctrl;
    logic clk = 1'b0;
    logic rst_n, hl_tick, vsync, std_sel, lsel_mode_n, frz_n, lsel_pulse, smp_tick;
    logic we, rw;
    int   n_chk = 0;
    int   n_err = 0;

    always #4 clk = ~clk;

    vid_wr_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .hl_tick(hl_tick), .vsync(vsync),
        .std_sel(std_sel), .lsel_mode_n(lsel_mode_n), .frz_n(frz_n),
        .lsel_pulse(lsel_pulse), .smp_tick(smp_tick), .we(we), .rw(rw)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) hl_tick = 1'b1;
            @(negedge clk) hl_tick = 1'b0;
        end
    endtask

    task automatic do_vsync();
        @(negedge clk) vsync = 1'b1;
        @(negedge clk) vsync = 1'b0;
        settle();
    endtask

    // one sample tick; returns rw one cycle later and the cycle after
    task automatic sample(output logic first, output logic second);
        @(negedge clk) smp_tick = 1'b1;
        @(negedge clk) smp_tick = 1'b0;
        first = rw;
        @(negedge clk);
        second = rw;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; hl_tick = 0; vsync = 0; std_sel = 1; lsel_mode_n = 1;
        frz_n = 1; lsel_pulse = 0; smp_tick = 0;
        repeat (3) @(negedge clk);
        chk("R1 we in reset", we, 1'b0);
        chk("R1 rw in reset", rw, 1'b0);
        rst_n = 1'b1;
        settle();
        chk("R1 we after reset (vbi)", we, 1'b0);
    endtask

    task automatic t_525();
        logic a, b;
        std_sel = 1; lsel_mode_n = 1;
        do_vsync();
        chk("R2 we at pos 0", we, 1'b0);
        ticks(41); settle();
        chk("R3 we at pos 41", we, 1'b0);
        sample(a, b);
        chk("R7 no rw in vbi", a, 1'b0);
        ticks(1); settle();
        chk("R3 we at pos 42", we, 1'b1);
        sample(a, b);
        chk("R6 rw after sample", a, 1'b1);
        chk("R6 rw one clock", b, 1'b0);
        do_vsync();
        chk("R2 vsync back to vbi", we, 1'b0);
    endtask

    task automatic t_625();
        std_sel = 0; lsel_mode_n = 1;
        do_vsync();
        ticks(45); settle();
        chk("R4 we at pos 45", we, 1'b0);
        ticks(4); settle();
        chk("R4 we at pos 49", we, 1'b0);
        ticks(1); settle();
        chk("R4 we at pos 50", we, 1'b1);
        std_sel = 1;
    endtask

    task automatic t_sat();
        std_sel = 1; lsel_mode_n = 1;
        do_vsync();
        ticks(4200); settle();
        chk("R5 no wrap after 4200 ticks", we, 1'b1);
    endtask

    task automatic t_line();
        logic a, b;
        std_sel = 1; lsel_mode_n = 1;
        do_vsync();
        ticks(100); settle();
        chk("R3 active before line mode", we, 1'b1);
        lsel_mode_n = 0; settle();
        chk("R9 no pulse no we", we, 1'b0);
        sample(a, b);
        chk("R9 no pulse no rw", a, 1'b0);
        @(negedge clk) lsel_pulse = 1'b1;
        @(negedge clk) lsel_pulse = 1'b0;
        settle();
        chk("R8 armed we", we, 1'b1);
        sample(a, b);
        chk("R8 armed rw", a, 1'b1);
        ticks(1); settle();   // tick at even position 100
        chk("R8 still armed mid-line", we, 1'b1);
        ticks(1); settle();   // tick at odd position 101 ends line
        chk("R8 disarmed at line end", we, 1'b0);
        do_vsync();
        @(negedge clk) lsel_pulse = 1'b1;
        @(negedge clk) lsel_pulse = 1'b0;
        settle();
        chk("R8 vbi ignored in line mode", we, 1'b1);
        do_vsync();
        chk("R11 vsync disarms", we, 1'b0);
        lsel_mode_n = 1;
    endtask

    task automatic t_freeze();
        logic a, b;
        std_sel = 1; lsel_mode_n = 1;
        do_vsync();
        ticks(60); settle();
        frz_n = 0; settle();
        chk("R10 freeze full-field we", we, 1'b0);
        sample(a, b);
        chk("R10 freeze rw", a, 1'b0);
        lsel_mode_n = 0;
        @(negedge clk) lsel_pulse = 1'b1;
        @(negedge clk) lsel_pulse = 1'b0;
        settle();
        chk("R10 freeze over armed line", we, 1'b0);
        frz_n = 1; settle();
        chk("R10 release restores line mode", we, 1'b1);
        lsel_mode_n = 1;
    endtask

    initial begin
        t_reset();
        t_525();
        t_625();
        t_line();
        t_freeze();
        t_sat();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_err++; n_chk++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule